// File: doc/BRIEF.md
# Instruction Fetch Block Extractor with Fetch-to-Decode Queue

This block is the front end of an in-order multi-issue core. Each cycle it presents the aligned address of the cache block that holds the current fetch PC. It receives the whole block back in the same cycle and cuts up to W sequential 4-byte instructions out of it, starting at the word the PC points to. The cut ends early for two reasons: the PC is too close to the end of the block, or a slot carries a predicted-taken bit. In the taken case the next PC is the supplied target. In the sequential case the PC advances past the words it took.

The extracted instructions, each with its PC, go into a FIFO that decouples fetch from decode. The queue absorbs the short fetch cycles caused by block ends and taken branches. Decode sees the oldest W entries and asks for up to W of them per cycle. A redirect, for example after a misprediction, empties the queue and restarts fetch at the corrected address.

Top module: `fetch_front`

## Requirements
- R1: While reset is asserted, the queue is empty, no decode slot is valid, and the fetch PC equals the reset PC, which is 0 by default.
- R2: With no taken prediction and room in the queue, an aligned fetch PC pushes W=4 instructions. Their PCs are pc, pc+4, pc+8 and pc+12 in program order. Each instruction is the 32-bit word at bits [32*j+31:32*j] of the block, where j is its word index.
- R3: A fetch pushes min(W, BLK_WORDS - j) instructions, with BLK_WORDS=8 and j = pc[4:2]. When the PC addresses the last word of the block, exactly one instruction is pushed.
- R4: Bit j of pred_taken marks word j of the block as predicted taken. Fetch stops after the first marked word among those it would take, and the next PC becomes pred_target. Marked words before the PC or after the stop point have no effect.
- R5: A fetch that pushes n instructions with no taken mark advances the PC by 4*n.
- R6: A fetch that would push n instructions stalls when the free entries before this cycle's pops (DEPTH minus q_count) are fewer than n. A stalled fetch pushes nothing and holds the PC.
- R7: Decode removes min(pop_req, q_count) entries per cycle, oldest first. deq_valid is valid for the oldest min(q_count, W) entries, contiguous from slot 0. Slot 0 is the oldest entry.
- R8: A redirect empties the queue in that cycle and loads the fetch PC with redirect_pc. Nothing is pushed in that cycle, and pop_req is ignored.
- R9: q_count never exceeds DEPTH=18. The queue fills to exactly 18, and program order is preserved across the wrap of its storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Flush queue and restart fetch |
| redirect_pc | input | 32 | Restart address |
| ic_addr | output | 32 | Block-aligned address of the current fetch PC |
| ic_block | input | 256 | Cache block contents, word j at bits [32*j+31:32*j] |
| pred_taken | input | 8 | Per-word predicted-taken marks for the current block |
| pred_target | input | 32 | Target used when a marked word ends the fetch |
| pop_req | input | 3 | Number of entries decode wants to take this cycle |
| fetch_pc | output | 32 | Current fetch PC |
| q_count | output | 5 | Number of queued instructions |
| deq_valid | output | 4 | Valid flags of the oldest four entries |
| deq_insn | output | 128 | Oldest four instructions, slot i at bits [32*i+31:32*i] |
| deq_pc | output | 128 | PCs of the oldest four instructions |

## Verification
Every cycle, the bound checker enforces the occupancy bound and the occupancy arithmetic, where pushes are added and clamped pops are subtracted. It also checks that decode slots are contiguous and match the occupancy, that a fetch never crosses the block end, and the PC update rule for each of the three cases: redirect, stall and normal fetch. Some behaviour is visible only in the directed scenarios: which instruction words and PCs land in which decode slot, the exact stop point when several taken marks are present, marks that lie before the PC, fill to the exact depth, and ordering after the storage pointer wraps.

// File: rtl/fetchq_pkg.sv
package fetchq_pkg;
    localparam int unsigned INSN_W     = 32;
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned INSN_SHIFT = $clog2(INSN_BYTES);
endpackage

// File: rtl/fetch_slicer.sv
// Cuts the sequential run of instructions out of one cache block.
module fetch_slicer #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BLK_WORDS = 8,
    parameter int unsigned W         = 4,
    localparam int unsigned IW       = fetchq_pkg::INSN_W,
    localparam int unsigned OFF_W    = $clog2(BLK_WORDS),
    localparam int unsigned POS_W    = $clog2(BLK_WORDS + W) + 1,
    localparam int unsigned CNT_W    = $clog2(W + 1)
) (
    input  logic [ADDR_W-1:0]       pc,
    input  logic [BLK_WORDS*IW-1:0] blk_data,
    input  logic [BLK_WORDS-1:0]    taken_bits,
    output logic [W*IW-1:0]         slot_insn,
    output logic [W*ADDR_W-1:0]     slot_pc,
    output logic [CNT_W-1:0]        n_slots,
    output logic                    hit_taken
);
    localparam int unsigned SH = fetchq_pkg::INSN_SHIFT;

    logic [OFF_W-1:0] off;
    logic [POS_W-1:0] pos;
    logic             stop;

    always_comb begin
        off       = pc[SH +: OFF_W];
        slot_insn = '0;
        slot_pc   = '0;
        n_slots   = '0;
        hit_taken = 1'b0;
        stop      = 1'b0;
        pos       = '0;
        for (int i = 0; i < W; i++) begin
            pos = POS_W'(off) + POS_W'(i);
            if (!stop && pos < POS_W'(BLK_WORDS)) begin
                slot_insn[i*IW +: IW]         = blk_data[{pos[OFF_W-1:0], 5'b0} +: IW];
                slot_pc[i*ADDR_W +: ADDR_W]   = pc + ADDR_W'(i * fetchq_pkg::INSN_BYTES);
                n_slots                       = n_slots + CNT_W'(1);
                if (taken_bits[pos[OFF_W-1:0]]) begin
                    stop      = 1'b1;
                    hit_taken = 1'b1;
                end
            end else begin
                stop = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fetch_queue.sv
// Multi-push, multi-pop circular queue between fetch and decode.
module fetch_queue #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned W      = 4,
    parameter int unsigned DEPTH  = 18,
    localparam int unsigned IW    = fetchq_pkg::INSN_W,
    localparam int unsigned CNT_W = $clog2(W + 1),
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned OCC_W = $clog2(DEPTH + 1),
    localparam int unsigned ENT_W = IW + ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [CNT_W-1:0]    push_n,
    input  logic [W*IW-1:0]     push_insn,
    input  logic [W*ADDR_W-1:0] push_pc,
    input  logic [CNT_W-1:0]    pop_req,
    output logic [OCC_W-1:0]    occ,
    output logic [W-1:0]        head_valid,
    output logic [W*IW-1:0]     head_insn,
    output logic [W*ADDR_W-1:0] head_pc
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [OCC_W-1:0] occ;
    } q_state_t;

    q_state_t         q_d, q_q;
    logic [ENT_W-1:0] mem [DEPTH];
    logic [OCC_W-1:0] pop_eff;

    function automatic logic [PTR_W-1:0] wrap_idx(input logic [PTR_W-1:0] base, input int off);
        int s;
        s = (int'(base) + off) % DEPTH;
        return PTR_W'(s);
    endfunction

    always_comb begin
        pop_eff = (OCC_W'(pop_req) > q_q.occ) ? q_q.occ : OCC_W'(pop_req);
        q_d     = q_q;
        if (flush) begin
            q_d.head = '0;
            q_d.occ  = '0;
        end else begin
            q_d.head = wrap_idx(q_q.head, int'(pop_eff));
            q_d.occ  = q_q.occ + OCC_W'(push_n) - pop_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < W; i++) begin
            if (!flush && i < int'(push_n))
                mem[wrap_idx(q_q.head, int'(q_q.occ) + i)] <=
                    {push_insn[i*IW +: IW], push_pc[i*ADDR_W +: ADDR_W]};
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            head_insn[i*IW +: IW]       = mem[wrap_idx(q_q.head, i)][ADDR_W +: IW];
            head_pc[i*ADDR_W +: ADDR_W] = mem[wrap_idx(q_q.head, i)][ADDR_W-1:0];
            head_valid[i]               = (OCC_W'(i) < q_q.occ);
        end
    end

    assign occ = q_q.occ;
endmodule

// File: rtl/fetch_front.sv
// Fetch stage: block address, extraction, stall and redirect control.
module fetch_front #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BLK_WORDS = 8,
    parameter int unsigned W         = 4,
    parameter int unsigned DEPTH     = 18,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    localparam int unsigned IW       = fetchq_pkg::INSN_W,
    localparam int unsigned CNT_W    = $clog2(W + 1),
    localparam int unsigned OCC_W    = $clog2(DEPTH + 1),
    localparam int unsigned BLK_LSB  = $clog2(BLK_WORDS) + fetchq_pkg::INSN_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    redirect_valid,
    input  logic [ADDR_W-1:0]       redirect_pc,
    output logic [ADDR_W-1:0]       ic_addr,
    input  logic [BLK_WORDS*IW-1:0] ic_block,
    input  logic [BLK_WORDS-1:0]    pred_taken,
    input  logic [ADDR_W-1:0]       pred_target,
    input  logic [CNT_W-1:0]        pop_req,
    output logic [ADDR_W-1:0]       fetch_pc,
    output logic [OCC_W-1:0]        q_count,
    output logic [W-1:0]            deq_valid,
    output logic [W*IW-1:0]         deq_insn,
    output logic [W*ADDR_W-1:0]     deq_pc
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } fe_state_t;

    fe_state_t           fe_d, fe_q;
    logic [W*IW-1:0]     slot_insn;
    logic [W*ADDR_W-1:0] slot_pc;
    logic [CNT_W-1:0]    n_slots;
    logic [CNT_W-1:0]    push_n;
    logic                hit_taken;
    logic                stall;
    logic [OCC_W-1:0]    free_slots;

    fetch_slicer #(.ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS), .W(W)) u_slicer (
        .pc        (fe_q.pc),
        .blk_data  (ic_block),
        .taken_bits(pred_taken),
        .slot_insn (slot_insn),
        .slot_pc   (slot_pc),
        .n_slots   (n_slots),
        .hit_taken (hit_taken)
    );

    always_comb begin
        free_slots = OCC_W'(DEPTH) - q_count;
        stall      = free_slots < OCC_W'(n_slots);
        push_n     = (redirect_valid || stall) ? '0 : n_slots;
        fe_d       = fe_q;
        if (redirect_valid)
            fe_d.pc = redirect_pc;
        else if (!stall)
            fe_d.pc = hit_taken ? pred_target
                                : fe_q.pc + (ADDR_W'(n_slots) << fetchq_pkg::INSN_SHIFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fe_q.pc <= RESET_PC;
        else        fe_q    <= fe_d;
    end

    fetch_queue #(.ADDR_W(ADDR_W), .W(W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redirect_valid),
        .push_n    (push_n),
        .push_insn (slot_insn),
        .push_pc   (slot_pc),
        .pop_req   (pop_req),
        .occ       (q_count),
        .head_valid(deq_valid),
        .head_insn (deq_insn),
        .head_pc   (deq_pc)
    );

    assign fetch_pc = fe_q.pc;
    assign ic_addr  = {fe_q.pc[ADDR_W-1:BLK_LSB], BLK_LSB'(0)};
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned BLK_WORDS = 8,
    parameter int unsigned W         = 4,
    parameter int unsigned DEPTH     = 18,
    localparam int unsigned CNT_W    = $clog2(W + 1),
    localparam int unsigned OCC_W    = $clog2(DEPTH + 1),
    localparam int unsigned OFF_W    = $clog2(BLK_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic [ADDR_W-1:0] pred_target,
    input logic [CNT_W-1:0]  pop_req,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [OCC_W-1:0]  q_count,
    input logic [W-1:0]      deq_valid,
    input logic [CNT_W-1:0]  push_n,
    input logic              stall,
    input logic              hit_taken
);
    int room_in_blk;
    int pop_clamped;
    int vis;

    always_comb begin
        room_in_blk = int'(BLK_WORDS) - int'(fetch_pc[2 +: OFF_W]);
        pop_clamped = (int'(pop_req) > int'(q_count)) ? int'(q_count) : int'(pop_req);
        vis         = (int'(q_count) > int'(W)) ? int'(W) : int'(q_count);
    end

    a_r9_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_count) <= int'(DEPTH));

    a_r8_redirect_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> (q_count == '0) && (fetch_pc == $past(redirect_pc)));

    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && stall) |=> $stable(fetch_pc));

    a_r4_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && !stall && hit_taken) |=> fetch_pc == $past(pred_target));

    a_r5_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_valid && !stall && !hit_taken) |=>
            fetch_pc == $past(fetch_pc) + ADDR_W'(4 * int'($past(push_n))));

    a_r3_block_limit: assert property (@(posedge clk) disable iff (!rst_n)
        int'(push_n) <= room_in_blk);

    a_r7_occ_update: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_valid |=>
            int'(q_count) == int'($past(q_count)) + int'($past(push_n)) - $past(pop_clamped));

    a_r7_visible_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(deq_valid) == vis);

    for (genvar i = 1; i < W; i++) begin : g_contig
        a_r7_slot_contig: assert property (@(posedge clk) disable iff (!rst_n)
            deq_valid[i] |-> deq_valid[i-1]);
    end
endmodule

bind fetch_front fetch_front_chk #(
    .ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS), .W(W), .DEPTH(DEPTH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .redirect_valid(redirect_valid),
    .redirect_pc   (redirect_pc),
    .pred_target   (pred_target),
    .pop_req       (pop_req),
    .fetch_pc      (fetch_pc),
    .q_count       (q_count),
    .deq_valid     (deq_valid),
    .push_n        (push_n),
    .stall         (stall),
    .hit_taken     (hit_taken)
);

// File: tb/fetch_front_tb.sv
`timescale 1ns/1ps
module fetch_front_tb;
    localparam int AW = 32;
    localparam int BW = 8;
    localparam int W  = 4;
    localparam int D  = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          redirect_valid = 1'b0;
    logic [AW-1:0] redirect_pc = '0;
    logic [AW-1:0] ic_addr;
    logic [BW*32-1:0] ic_block;
    logic [BW-1:0] pred_taken = '0;
    logic [AW-1:0] pred_target = '0;
    logic [2:0]    pop_req = '0;
    logic [AW-1:0] fetch_pc;
    logic [4:0]    q_count;
    logic [W-1:0]  deq_valid;
    logic [W*32-1:0] deq_insn;
    logic [W*AW-1:0] deq_pc;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #4 clk = ~clk;

    fetch_front u_dut (
        .clk(clk), .rst_n(rst_n), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .ic_addr(ic_addr), .ic_block(ic_block), .pred_taken(pred_taken),
        .pred_target(pred_target), .pop_req(pop_req), .fetch_pc(fetch_pc),
        .q_count(q_count), .deq_valid(deq_valid), .deq_insn(deq_insn), .deq_pc(deq_pc)
    );

    function automatic logic [31:0] word_at(input logic [AW-1:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    // Instruction memory: whole block returned for the presented address.
    always_comb begin
        for (int j = 0; j < BW; j++) ic_block[j*32 +: 32] = word_at(ic_addr + AW'(4 * j));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_slot(input string tag, input int i, input logic [AW-1:0] exp_pc);
        chk(tag, $sformatf("slot%0d valid", i), deq_valid[i], 1);
        chk(tag, $sformatf("slot%0d pc", i), deq_pc[i*AW +: AW], exp_pc);
        chk(tag, $sformatf("slot%0d insn", i), deq_insn[i*32 +: 32], word_at(exp_pc));
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic redirect_to(input logic [AW-1:0] tgt, input logic [2:0] pops);
        redirect_valid = 1'b1;
        redirect_pc    = tgt;
        pop_req        = pops;
        cyc();
        redirect_valid = 1'b0;
        pop_req        = '0;
        chk("R8", "count after redirect", q_count, 0);
        chk("R8", "pc after redirect", fetch_pc, tgt);
    endtask

    task automatic t_reset();
        cyc(); cyc();
        chk("R1", "count in reset", q_count, 0);
        chk("R1", "valid in reset", deq_valid, 0);
        chk("R1", "pc in reset", fetch_pc, 0);
        chk("R1", "block addr in reset", ic_addr, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_aligned();
        redirect_to(32'h80, 3'd0);
        cyc();
        chk("R2", "count", q_count, 4);
        for (int i = 0; i < W; i++) chk_slot("R2", i, 32'h80 + AW'(4 * i));
        chk("R5", "next pc", fetch_pc, 32'h90);
    endtask

    task automatic t_block_end();
        redirect_to(32'h1C, 3'd0);
        cyc();
        chk("R3", "count last word", q_count, 1);
        chk_slot("R3", 0, 32'h1C);
        chk("R3", "slot1 invalid", deq_valid[1], 0);
        chk("R5", "pc after one", fetch_pc, 32'h20);
        pop_req = 3'd4;
        cyc();
        pop_req = 3'd0;
        chk("R7", "count after over-pop", q_count, 4);
        chk_slot("R7", 0, 32'h20);
        redirect_to(32'h14, 3'd0);
        cyc();
        chk("R3", "count three left", q_count, 3);
        for (int i = 0; i < 3; i++) chk_slot("R3", i, 32'h14 + AW'(4 * i));
        chk("R3", "pc to next block", fetch_pc, 32'h20);
    endtask

    task automatic t_taken();
        pred_taken  = 8'b0000_0110;
        pred_target = 32'h100;
        redirect_to(32'h40, 3'd0);
        cyc();
        pred_taken = '0;
        chk("R4", "count stops at first mark", q_count, 2);
        chk("R4", "pc to target", fetch_pc, 32'h100);
        cyc();
        chk("R4", "count after target fetch", q_count, 6);
        chk_slot("R4", 0, 32'h40);
        chk_slot("R4", 1, 32'h44);
        chk_slot("R4", 2, 32'h100);
        chk_slot("R4", 3, 32'h104);
        pred_taken  = 8'b0000_1001;
        pred_target = 32'h200;
        redirect_to(32'h48, 3'd4);
        cyc();
        pred_taken = '0;
        chk("R4", "mark before pc ignored", q_count, 2);
        chk_slot("R4", 1, 32'h4C);
        chk("R4", "pc to second target", fetch_pc, 32'h200);
        redirect_to(32'h300, 3'd4);
        cyc();
        chk("R8", "restart at target", q_count, 4);
        chk_slot("R8", 0, 32'h300);
    endtask

    task automatic t_fill_and_wrap();
        logic [AW-1:0] head;
        redirect_to(32'h0, 3'd0);
        for (int k = 1; k <= 4; k++) begin
            cyc();
            chk("R2", "fill count", q_count, 4 * k);
        end
        cyc();
        chk("R6", "stall count", q_count, 16);
        chk("R6", "stall pc", fetch_pc, 32'h40);
        pop_req = 3'd2;
        cyc();
        pop_req = 3'd0;
        chk("R6", "still stalled", q_count, 14);
        chk("R6", "pc held", fetch_pc, 32'h40);
        chk_slot("R7", 0, 32'h8);
        cyc();
        chk("R9", "full", q_count, 18);
        chk("R9", "pc after fill", fetch_pc, 32'h50);
        cyc();
        chk("R9", "stays full", q_count, 18);
        pop_req = 3'd3;
        cyc();
        chk("R7", "pop three", q_count, 15);
        chk_slot("R7", 0, 32'h14);
        pop_req = 3'd4;
        cyc();
        chk("R6", "stall three free", q_count, 11);
        head = 32'h24;
        for (int k = 0; k < 6; k++) begin
            chk_slot("R9", 0, head);
            chk_slot("R9", 3, head + 32'hC);
            cyc();
            head = head + 32'h10;
            chk("R9", "steady count", q_count, 11);
        end
        pop_req = 3'd0;
    endtask

    initial begin
        t_reset();
        t_aligned();
        t_block_end();
        t_taken();
        t_fill_and_wrap();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule